// File: doc/BRIEF.md
# Timer Output-Compare Unit with Event Trigger

This block pairs a free-running 16-bit up-counter with a 16-bit compare register. When the counter value equals the compare value, the block carries out the action chosen by a 4-bit mode field. It can drive a sticky output latch high, drive it low, or only raise an interrupt flag. In trigger mode it returns the counter to zero and sends a one-cycle start request to an attached analog-to-digital converter.

Software loads the compare value and the mode through two write strobes. It clears the interrupt flag and the counter overflow flag with clear strobes. The counter advances only while the increment enable is high. In trigger mode the compare register works as a programmable period: the counter runs from zero up to the compare value and then starts again. A counter reset caused by the trigger is not a wrap, so it never raises the overflow flag.

Top module: `cmp_timer_unit`

## Requirements
- R1: After synchronous reset the counter, the compare register, the mode, the output latch, the interrupt flag, the overflow flag and the conversion request are all zero.
- R2: The counter adds one on each clock edge where `tick_en` is high and holds otherwise. A step from 16'hFFFF to 0 sets `ovf_flag`. `ovf_clr` clears `ovf_flag`, and a wrap in the same cycle wins over the clear.
- R3: In mode 4'b1000 a match drives `compare_out` high one clock later. In mode 4'b1001 a match drives it low one clock later.
- R4: In mode 4'b1010 a match sets only `cmp_flag`, and `compare_out` keeps its value.
- R5: In mode 4'b1011 a match loads the counter with zero on the next clock instead of incrementing it. With `tick_en` held high the counter therefore cycles through 0 up to the compare value.
- R6: A counter reset caused by a mode 4'b1011 match never sets `ovf_flag`. This holds even when the match occurs at 16'hFFFF with `tick_en` high.
- R7: A mode 4'b1011 match gives a one-cycle `conv_start` pulse on the next clock, but only while `conv_en` is high.
- R8: A match in any of the modes 4'b1000 to 4'b1011 sets `cmp_flag` one clock later. Every other mode value disables compare, so a match has no effect.
- R9: `cmp_flag` stays set until a `flag_clr` strobe. If a clear and a new match occur in the same cycle, the flag stays set.
- R10: A match acts only once for each counter value. While the counter holds at the matching value, neither the flag nor the trigger fires again. A write to the compare register or to the mode re-arms detection.
- R11: Writing 4'b0000 to the mode forces `compare_out` low on the next clock. Writing any other value leaves `compare_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_wr | input | 1 | Write strobe for the compare register |
| cmp_wdata | input | 16 | New compare value |
| mode_wr | input | 1 | Write strobe for the mode field |
| mode_wdata | input | 4 | New mode value |
| flag_clr | input | 1 | Clears the compare interrupt flag |
| ovf_clr | input | 1 | Clears the counter overflow flag |
| tick_en | input | 1 | Counter increment enable |
| conv_en | input | 1 | The converter is enabled and accepts start requests |
| timer_val | output | 16 | Present counter value |
| compare_out | output | 1 | Compare output latch |
| cmp_flag | output | 1 | Compare interrupt flag |
| ovf_flag | output | 1 | Counter overflow flag |
| conv_start | output | 1 | One-cycle conversion start request |

## Verification
A wrong match-arming state shows up one clock after the counter reaches the compare value. Either `cmp_flag` fails to rise, or it rises again after a clear while the counter is held. A wrong counter or trigger path shows up on `timer_val` within one clock: the count does not return to zero at the period, or it steps by something other than one. The overflow path has its own risk. A wrong overflow qualifier raises `ovf_flag` on a trigger reset at 16'hFFFF, so the bench drives the counter through that exact value in trigger mode. Every output is compared cycle by cycle with a model built from the requirements, so any divergence is reported on the clock where it first appears.

// File: rtl/cmpu_pkg.sv
package cmpu_pkg;

    localparam int TMR_W  = 16;
    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        CM_OFF = 4'b0000,
        CM_SET = 4'b1000,
        CM_CLR = 4'b1001,
        CM_SWI = 4'b1010,
        CM_SEV = 4'b1011
    } cm_mode_e;

    typedef struct packed {
        logic hit;
        logic go_hi;
        logic go_lo;
        logic sev;
    } cmp_evt_t;

    function automatic logic mode_active(input logic [MODE_W-1:0] m);
        return (m == CM_SET) || (m == CM_CLR) || (m == CM_SWI) || (m == CM_SEV);
    endfunction

    function automatic cmp_evt_t decode_evt(input logic raw, input logic [MODE_W-1:0] m);
        cmp_evt_t ev;
        ev.hit   = raw && mode_active(m);
        ev.go_hi = ev.hit && (m == CM_SET);
        ev.go_lo = ev.hit && (m == CM_CLR);
        ev.sev   = ev.hit && (m == CM_SEV);
        return ev;
    endfunction

endpackage

// File: rtl/cmpu_timer.sv
module cmpu_timer
    import cmpu_pkg::*;
#(
    parameter int W = TMR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_en,
    input  logic         sev_rst,
    input  logic         ovf_clr,
    output logic [W-1:0] tmr_q,
    output logic [W-1:0] tmr_nxt,
    output logic         ovf_q
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic wrap;

    always_comb begin
        wrap = tick_en && (tmr_q == TOP) && !sev_rst;
        if (sev_rst)
            tmr_nxt = '0;
        else if (tick_en)
            tmr_nxt = tmr_q + 1'b1;
        else
            tmr_nxt = tmr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            tmr_q <= tmr_nxt;
            if (wrap)
                ovf_q <= 1'b1;
            else if (ovf_clr)
                ovf_q <= 1'b0;
        end
    end

    assert_ovf_only_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_q) |-> ($past(tmr_q) == TOP) && $past(tick_en) && !$past(sev_rst));

    assert_tmr_step_R2: assert property (@(posedge clk) disable iff (rst)
        (tmr_q != $past(tmr_q)) |-> ((tmr_q == $past(tmr_q) + 1'b1) || (tmr_q == '0)));

endmodule

// File: rtl/cmpu_match.sv
module cmpu_match
    import cmpu_pkg::*;
#(
    parameter int W = TMR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      tmr_q,
    input  logic [W-1:0]      tmr_nxt,
    input  logic [W-1:0]      cmp_q,
    input  logic [MODE_W-1:0] mode_q,
    input  logic              rearm,
    output cmp_evt_t          evt
);

    logic seen_q;

    always_comb begin
        evt = decode_evt((tmr_q == cmp_q) && !seen_q, mode_q);
    end

    always_ff @(posedge clk) begin
        if (rst)
            seen_q <= 1'b0;
        else if (rearm || (tmr_nxt != tmr_q))
            seen_q <= 1'b0;
        else if (evt.hit)
            seen_q <= 1'b1;
    end

    assert_single_hit_R10: assert property (@(posedge clk) disable iff (rst)
        evt.hit |=> (!evt.hit || $past(rearm)));

endmodule

// File: rtl/cmpu_action.sv
module cmpu_action
    import cmpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cmp_evt_t          evt,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              flag_clr,
    input  logic              conv_en,
    output logic              pin_q,
    output logic              flag_q,
    output logic              conv_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q  <= 1'b0;
            flag_q <= 1'b0;
            conv_q <= 1'b0;
        end else begin
            if (mode_wr && (mode_wdata == CM_OFF))
                pin_q <= 1'b0;
            else if (evt.go_hi)
                pin_q <= 1'b1;
            else if (evt.go_lo)
                pin_q <= 1'b0;

            if (evt.hit)
                flag_q <= 1'b1;
            else if (flag_clr)
                flag_q <= 1'b0;

            conv_q <= evt.sev && conv_en;
        end
    end

    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !flag_clr) |=> flag_q);

    assert_conv_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        conv_q |=> !conv_q);

    assert_pin_off_R11: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && (mode_wdata == CM_OFF)) |=> !pin_q);

endmodule

// File: rtl/cmp_timer_unit.sv
module cmp_timer_unit
    import cmpu_pkg::*;
#(
    parameter int W = TMR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_wr,
    input  logic [W-1:0]      cmp_wdata,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              flag_clr,
    input  logic              ovf_clr,
    input  logic              tick_en,
    input  logic              conv_en,
    output logic [W-1:0]      timer_val,
    output logic              compare_out,
    output logic              cmp_flag,
    output logic              ovf_flag,
    output logic              conv_start
);

    logic [W-1:0]      cmp_q;
    logic [MODE_W-1:0] mode_q;
    logic [W-1:0]      tmr_q;
    logic [W-1:0]      tmr_nxt;
    cmp_evt_t          evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q  <= '0;
            mode_q <= CM_OFF;
        end else begin
            if (cmp_wr)
                cmp_q <= cmp_wdata;
            if (mode_wr)
                mode_q <= mode_wdata;
        end
    end

    cmpu_timer #(.W(W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .sev_rst (evt.sev),
        .ovf_clr (ovf_clr),
        .tmr_q   (tmr_q),
        .tmr_nxt (tmr_nxt),
        .ovf_q   (ovf_flag)
    );

    cmpu_match #(.W(W)) u_match (
        .clk     (clk),
        .rst     (rst),
        .tmr_q   (tmr_q),
        .tmr_nxt (tmr_nxt),
        .cmp_q   (cmp_q),
        .mode_q  (mode_q),
        .rearm   (cmp_wr || mode_wr),
        .evt     (evt)
    );

    cmpu_action u_action (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .flag_clr   (flag_clr),
        .conv_en    (conv_en),
        .pin_q      (compare_out),
        .flag_q     (cmp_flag),
        .conv_q     (conv_start)
    );

    assign timer_val = tmr_q;

    assert_sev_zero_R5: assert property (@(posedge clk) disable iff (rst)
        evt.sev |=> (timer_val == '0));

endmodule

// File: tb/sim_cmp_timer_unit.sv
`timescale 1ns/1ps
module sim_cmp_timer_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmp_wr = 0, mode_wr = 0, flag_clr = 0, ovf_clr = 0, tick_en = 0, conv_en = 0;
    logic [15:0] cmp_wdata = '0;
    logic [3:0]  mode_wdata = '0;
    logic [15:0] timer_val;
    logic        compare_out, cmp_flag, ovf_flag, conv_start;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cmp_timer_unit u0 (
        .clk(clk), .rst(rst), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata), .flag_clr(flag_clr),
        .ovf_clr(ovf_clr), .tick_en(tick_en), .conv_en(conv_en),
        .timer_val(timer_val), .compare_out(compare_out), .cmp_flag(cmp_flag),
        .ovf_flag(ovf_flag), .conv_start(conv_start)
    );

    // reference state built from the requirements
    logic [15:0] m_tmr, m_cmp;
    logic [3:0]  m_mode;
    logic        m_seen, m_pin, m_flag, m_ovf, m_conv;
    int          conv_cnt = 0;
    int          max_tmr = 0;

    function automatic bit active_mode(input logic [3:0] m);
        return m >= 4'b1000 && m <= 4'b1011;
    endfunction

    always @(posedge clk) begin
        logic hit, sev;
        logic [15:0] nxt;
        if (rst) begin
            m_tmr = 0; m_cmp = 0; m_mode = 0; m_seen = 0;
            m_pin = 0; m_flag = 0; m_ovf = 0; m_conv = 0;
        end else begin
            hit = active_mode(m_mode) && (m_tmr == m_cmp) && !m_seen;
            sev = hit && (m_mode == 4'b1011);
            nxt = sev ? 16'h0 : (tick_en ? m_tmr + 16'h1 : m_tmr);
            if (tick_en && m_tmr == 16'hFFFF && !sev) m_ovf = 1;
            else if (ovf_clr) m_ovf = 0;
            if (cmp_wr || mode_wr || nxt != m_tmr) m_seen = 0;
            else if (hit) m_seen = 1;
            if (mode_wr && mode_wdata == 4'b0000) m_pin = 0;
            else if (hit && m_mode == 4'b1000) m_pin = 1;
            else if (hit && m_mode == 4'b1001) m_pin = 0;
            if (hit) m_flag = 1;
            else if (flag_clr) m_flag = 0;
            m_conv = sev && conv_en;
            m_tmr = nxt;
            if (cmp_wr) m_cmp = cmp_wdata;
            if (mode_wr) m_mode = mode_wdata;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2 R5 timer", timer_val, m_tmr);
            chk("R3 R4 R11 compare_out", compare_out, m_pin);
            chk("R8 R9 R10 cmp_flag", cmp_flag, m_flag);
            chk("R2 R6 ovf_flag", ovf_flag, m_ovf);
            chk("R7 conv_start", conv_start, m_conv);
            if (conv_start) conv_cnt++;
            if (int'(timer_val) > max_tmr) max_tmr = int'(timer_val);
        end
    end

    task automatic slot();
        @(posedge clk); #1;
    endtask

    task automatic idle_strobes();
        cmp_wr = 0; mode_wr = 0; flag_clr = 0; ovf_clr = 0;
    endtask

    task automatic wr_cmp(input logic [15:0] v);
        slot(); idle_strobes(); cmp_wr = 1; cmp_wdata = v;
        slot(); idle_strobes();
    endtask

    task automatic wr_mode(input logic [3:0] v);
        slot(); idle_strobes(); mode_wr = 1; mode_wdata = v;
        slot(); idle_strobes();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) slot();
    endtask

    initial begin
        #(5.0 * 190000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        logic [15:0] held;
        seed = 7;
        void'($urandom(seed));
        run(3);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        chk("R1 timer", timer_val, 0);
        chk("R1 compare_out", compare_out, 0);
        chk("R1 cmp_flag", cmp_flag, 0);
        chk("R1 ovf_flag", ovf_flag, 0);
        chk("R1 conv_start", conv_start, 0);

        // R5/R7: trigger mode makes compare a period register
        conv_en = 1;
        wr_cmp(16'd3);
        wr_mode(4'b1011);
        tick_en = 1;
        run(2);
        max_tmr = 0; conv_cnt = 0;
        run(40);
        @(negedge clk);
        chk("R5 period max", max_tmr, 3);
        chk("R7 conv pulses", conv_cnt > 5, 1);

        // R6: trigger at 16'hFFFF must not set overflow
        tick_en = 0;
        slot(); ovf_clr = 1; slot(); ovf_clr = 0;
        wr_cmp(16'hFFFF);
        tick_en = 1;
        run(65545);
        @(negedge clk);
        chk("R6 no ovf on trigger", ovf_flag, 0);

        // R2 and R3: true wrap with set-high mode
        wr_cmp(16'h1234);
        wr_mode(4'b1000);
        run(65545);
        @(negedge clk);
        chk("R2 wrap ovf", ovf_flag, 1);
        chk("R3 set high", compare_out, 1);

        // R4 and R10: held counter, software-interrupt mode
        tick_en = 0;
        slot(); flag_clr = 1; slot(); flag_clr = 0;
        @(negedge clk); held = timer_val;
        wr_mode(4'b1010);
        wr_cmp(held);
        run(2);
        @(negedge clk);
        chk("R8 flag on swi match", cmp_flag, 1);
        chk("R4 pin unchanged", compare_out, 1);
        slot(); flag_clr = 1; slot(); flag_clr = 0;
        run(6);
        @(negedge clk);
        chk("R10 no rematch while held", cmp_flag, 0);

        // R9: clear and match in the same cycle
        slot(); idle_strobes(); cmp_wr = 1; cmp_wdata = held;
        slot(); idle_strobes(); flag_clr = 1;
        slot(); idle_strobes();
        @(negedge clk);
        chk("R9 match beats clear", cmp_flag, 1);

        // R3 clear-low then R11
        wr_mode(4'b1001);
        wr_cmp(held);
        run(2);
        @(negedge clk);
        chk("R3 drive low", compare_out, 0);
        wr_mode(4'b1000);
        wr_cmp(held);
        run(2);
        wr_mode(4'b0110);
        @(negedge clk);
        chk("R11 other mode keeps pin", compare_out, 1);
        wr_cmp(held);
        run(2);
        @(negedge clk);
        chk("R8 disabled mode no effect", compare_out, 1);
        wr_mode(4'b0000);
        @(negedge clk);
        chk("R11 zero mode forces low", compare_out, 0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            slot();
            idle_strobes();
            tick_en  = ($urandom % 4) != 0;
            conv_en  = $urandom % 2;
            flag_clr = ($urandom % 8) == 0;
            ovf_clr  = ($urandom % 16) == 0;
            if (($urandom % 10) == 0) begin
                cmp_wr = 1;
                cmp_wdata = timer_val + 16'($urandom % 12);
            end
            if (($urandom % 25) == 0) begin
                mode_wr = 1;
                case ($urandom % 6)
                    0: mode_wdata = 4'b1000;
                    1: mode_wdata = 4'b1001;
                    2: mode_wdata = 4'b1010;
                    3: mode_wdata = 4'b1011;
                    4: mode_wdata = 4'b0000;
                    default: mode_wdata = 4'($urandom % 8);
                endcase
            end
        end
        slot(); idle_strobes();
        run(3);
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule